// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It takes the memory device from power-on to a programmed, ready state. It holds clock-enable low and keeps the command bus idle until the supply is reported stable for a programmed number of cycles. It then raises clock-enable and walks a fixed list of eleven commands: precharge-all operations, loads of the four mode registers, and two refreshes. Each command goes out with the bank-select and address coding the device expects, and each one is followed by the idle spacing that the command calls for.

Every delay is a parameter given in clock cycles. The sequencer takes the user's main mode word and extended mode word, plus a high-temperature refresh select. It masks these values so that the DLL-enable, DLL-reset and driver-calibration passes carry the bits each pass needs. A separate DLL-lock count starts at the DLL-reset command and runs alongside the rest of the sequence. The ready flag rises only when both that count and the spacing after the last mode load have expired. After that the bus stays idle until the next reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke`, `cmd`, `ba`, `addr` and `init_done` are all zero.
- R2: `cke` rises exactly `T_PWR` cycles after the first cycle in which `pwr_ok` is sampled high, counting only an unbroken run of high samples. A low sample restarts the count, and `cmd` is NOP (0) for as long as `cke` is low.
- R3: The first command is a precharge-all (`cmd`=1, `addr` = bit 10 only, `ba`=0), issued exactly `T_CKE` cycles after `cke` rises. `cke` never falls again before reset.
- R4: The command codes on `cmd` are NOP=0, PRE=1, LOAD=2, REF=3. Exactly eleven non-NOP commands are issued, in this order, with these `ba` values: PRE(0), LOAD(2), LOAD(3), LOAD(1), LOAD(0), PRE(0), REF(0), REF(0), LOAD(0), LOAD(1), LOAD(1). Both REF commands have `addr`=0.
- R5: The LOAD with `ba`=2 carries `temp_hi` on address bit 7 and zero on every other bit.
- R6: The LOAD with `ba`=3 carries an all-zero address.
- R7: The first LOAD with `ba`=1 (DLL enable) carries `emr_cfg` with bits 0, 7, 8 and 9 forced to 0.
- R8: The first LOAD with `ba`=0 (DLL reset) carries an address with only bit 8 set.
- R9: The second LOAD with `ba`=0 carries `mr_cfg` with bit 8 forced to 0.
- R10: The second LOAD with `ba`=1 carries `emr_cfg` with bit 0 at 0 and bits 9:7 at 1. The third LOAD with `ba`=1 carries `emr_cfg` with bits 0 and 9:7 at 0.
- R11: The command after a LOAD follows it by exactly `T_MRD` cycles. The command after a PRE follows by `T_RP` cycles, and the command after a REF follows by `T_RFC` cycles. Every other cycle carries NOP.
- R12: `init_done` rises at the later of (last LOAD + `T_MRD`) and (DLL-reset LOAD + `T_DLL`). It then stays high with `cmd` at NOP until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock reported stable |
| temp_hi | input | 1 | Selects the doubled refresh rate in the ba=2 load |
| mr_cfg | input | AW | User main mode word |
| emr_cfg | input | AW | User extended mode word |
| cke | output | 1 | Clock enable to the device |
| cmd | output | 2 | Command code (NOP=0, PRE=1, LOAD=2, REF=3) |
| ba | output | 2 | Bank select for the command |
| addr | output | AW | Address bus for the command |
| init_done | output | 1 | Device programmed and DLL locked |

## Verification
Two timers finish independently: the spacing that follows the last extended-mode load, and the DLL-lock count that started at the DLL-reset load. One instance sets `T_DLL` to exactly the sum of the gaps from the DLL-reset load to the end of the final load's `T_MRD` wait, so both timers expire in the same cycle. A second instance sets `T_DLL` longer than that sum, so the lock count decides the release. In both cases the ready flag's rise cycle is compared with the later of the two expected expiry points, and any early rise, late rise or duplicated rise is reported. The shorter instance also uses single-cycle gaps, so commands appear back to back.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_REF  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PH_PWR,
        PH_CKE,
        PH_SEQ,
        PH_DONE
    } phase_e;

    localparam int NUM_CMDS = 11;
    localparam int STEP_W   = 4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_dnc.sv
// Down counter that loads a value and stops at zero; used for the DLL-lock wait.
module ddr2_init_dnc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_step.sv
// Step decoder: command, bank select, address and following gap for each step.
module ddr2_init_step
    import ddr2_init_pkg::*;
#(
    parameter int AW    = 13,
    parameter int CW    = 8,
    parameter int T_RP  = 2,
    parameter int T_MRD = 2,
    parameter int T_RFC = 16
) (
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     mr_cfg,
    input  logic [AW-1:0]     emr_cfg,
    input  logic              temp_hi,
    output cmd_e              cmd,
    output logic [1:0]        ba,
    output logic [AW-1:0]     addr,
    output logic [CW-1:0]     gap,
    output logic              dll_rst
);
    localparam logic [AW-1:0] BIT0  = AW'(1);
    localparam logic [AW-1:0] BIT7  = AW'(1) << 7;
    localparam logic [AW-1:0] BIT8  = AW'(1) << 8;
    localparam logic [AW-1:0] BIT10 = AW'(1) << 10;
    localparam logic [AW-1:0] OCD   = AW'(7) << 7;
    localparam logic [CW-1:0] G_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] G_MRD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] G_RFC = CW'(T_RFC - 1);

    always_comb begin
        cmd     = CMD_LOAD;
        ba      = 2'd0;
        addr    = '0;
        gap     = G_MRD;
        dll_rst = 1'b0;
        case (step)
            4'd0, 4'd5: begin
                cmd  = CMD_PRE;
                addr = BIT10;
                gap  = G_RP;
            end
            4'd1: begin
                ba   = 2'd2;
                addr = temp_hi ? BIT7 : '0;
            end
            4'd2: ba = 2'd3;
            4'd3: begin
                ba   = 2'd1;
                addr = emr_cfg & ~(OCD | BIT0);
            end
            4'd4: begin
                addr    = BIT8;
                dll_rst = 1'b1;
            end
            4'd6, 4'd7: begin
                cmd = CMD_REF;
                gap = G_RFC;
            end
            4'd8: addr = mr_cfg & ~BIT8;
            4'd9: begin
                ba   = 2'd1;
                addr = (emr_cfg & ~BIT0) | OCD;
            end
            4'd10: begin
                ba   = 2'd1;
                addr = emr_cfg & ~(OCD | BIT0);
            end
            default: begin
                cmd = CMD_NOP;
                gap = '0;
            end
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int AW    = 13,
    parameter int T_PWR = 25000,
    parameter int T_CKE = 50,
    parameter int T_RP  = 2,
    parameter int T_MRD = 2,
    parameter int T_RFC = 16,
    parameter int T_DLL = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          temp_hi,
    input  logic [AW-1:0] mr_cfg,
    input  logic [AW-1:0] emr_cfg,
    output logic          cke,
    output logic [1:0]    cmd,
    output logic [1:0]    ba,
    output logic [AW-1:0] addr,
    output logic          init_done
);
    localparam int MAXW = imax(imax(imax(T_PWR, T_CKE), imax(T_RP, T_MRD)), T_RFC);
    localparam int CW   = $clog2(MAXW + 1);
    localparam int DW   = $clog2(T_DLL + 1);

    typedef struct packed {
        phase_e            ph;
        logic [STEP_W-1:0] step;
        logic [CW-1:0]     cnt;
        logic              cke;
        logic [1:0]        cmd;
        logic [1:0]        ba;
        logic [AW-1:0]     addr;
        logic              done;
    } st_t;

    st_t  st_d, st_q;
    cmd_e dec_cmd;
    logic [1:0]    dec_ba;
    logic [AW-1:0] dec_addr;
    logic [CW-1:0] dec_gap;
    logic          dec_dll;
    logic          dll_load, dll_zero, issue;

    ddr2_init_step #(.AW(AW), .CW(CW), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)) u_step (
        .step(st_q.step), .mr_cfg(mr_cfg), .emr_cfg(emr_cfg), .temp_hi(temp_hi),
        .cmd(dec_cmd), .ba(dec_ba), .addr(dec_addr), .gap(dec_gap), .dll_rst(dec_dll)
    );

    ddr2_init_dnc #(.W(DW)) u_dll (
        .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(DW'(T_DLL - 1)), .zero(dll_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.ba   = 2'd0;
        st_d.addr = '0;
        issue     = 1'b0;
        dll_load  = 1'b0;
        case (st_q.ph)
            PH_PWR: begin
                if (!pwr_ok) begin
                    st_d.cnt = CW'(T_PWR - 1);
                end else if (st_q.cnt == '0) begin
                    st_d.ph  = PH_CKE;
                    st_d.cke = 1'b1;
                    st_d.cnt = CW'(T_CKE - 1);
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            PH_CKE: begin
                if (st_q.cnt == '0) issue = 1'b1;
                else                st_d.cnt = st_q.cnt - CW'(1);
            end
            PH_SEQ: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end else if (st_q.step == STEP_W'(NUM_CMDS)) begin
                    if (dll_zero) begin
                        st_d.ph   = PH_DONE;
                        st_d.done = 1'b1;
                    end
                end else begin
                    issue = 1'b1;
                end
            end
            default: ;
        endcase
        if (issue) begin
            st_d.ph   = PH_SEQ;
            st_d.cmd  = dec_cmd;
            st_d.ba   = dec_ba;
            st_d.addr = dec_addr;
            st_d.cnt  = dec_gap;
            st_d.step = st_q.step + STEP_W'(1);
            dll_load  = dec_dll;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_PWR;
            st_q.cnt  <= CW'(T_PWR - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cke       = st_q.cke;
    assign cmd       = st_q.cmd;
    assign ba        = st_q.ba;
    assign addr      = st_q.addr;
    assign init_done = st_q.done;

    // R2: the bus stays idle while the device clock is disabled
    a_r2_idle_without_cke: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == CMD_NOP);

    // R3: clock enable never drops once raised
    a_r3_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R3: precharge-all always carries address bit 10 alone
    a_r3_pre_all_coding: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |-> addr == (AW'(1) << 10));

    // R5: refresh-rate load carries nothing but bit 7
    a_r5_emr2_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD && ba == 2'd2) |-> (addr & ~(AW'(1) << 7)) == '0);

    // R12: ready stays high and the bus stays idle afterwards
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r12_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cmd == CMD_NOP);

    generate
        if (T_MRD > 1) begin : g_mrd_chk
            // R11: a mode load is followed by at least one idle cycle
            a_r11_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                $past(cmd) == CMD_LOAD |-> cmd == CMD_NOP);
        end
    endgenerate
endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
    localparam int AW = 13;
    localparam int A_PWR = 20, A_CKE = 5, A_RP = 3, A_MRD = 2, A_RFC = 9, A_DLL = 40;
    localparam int B_PWR = 12, B_CKE = 1, B_RP = 1, B_MRD = 1, B_RFC = 4, B_DLL = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_ok = 1'b0, temp_hi = 1'b0;
    logic [AW-1:0] mr_cfg = '0, emr_cfg = '0;

    logic cke_a, done_a, cke_b, done_b;
    logic [1:0] cmd_a, ba_a, cmd_b, ba_b;
    logic [AW-1:0] addr_a, addr_b;

    always #4 clk = ~clk;

    ddr2_init_seq #(.AW(AW), .T_PWR(A_PWR), .T_CKE(A_CKE), .T_RP(A_RP), .T_MRD(A_MRD),
                    .T_RFC(A_RFC), .T_DLL(A_DLL)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .temp_hi(temp_hi), .mr_cfg(mr_cfg),
        .emr_cfg(emr_cfg), .cke(cke_a), .cmd(cmd_a), .ba(ba_a), .addr(addr_a), .init_done(done_a));

    ddr2_init_seq #(.AW(AW), .T_PWR(B_PWR), .T_CKE(B_CKE), .T_RP(B_RP), .T_MRD(B_MRD),
                    .T_RFC(B_RFC), .T_DLL(B_DLL)) dut2 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .temp_hi(temp_hi), .mr_cfg(mr_cfg),
        .emr_cfg(emr_cfg), .cke(cke_b), .cmd(cmd_b), .ba(ba_b), .addr(addr_b), .init_done(done_b));

    int t_pwr [2] = '{A_PWR, B_PWR};
    int t_cke [2] = '{A_CKE, B_CKE};
    int t_rp  [2] = '{A_RP,  B_RP};
    int t_mrd [2] = '{A_MRD, B_MRD};
    int t_rfc [2] = '{A_RFC, B_RFC};
    int t_dll [2] = '{A_DLL, B_DLL};

    int checks = 0, fails = 0, cyc = 0, run_start = 0;
    bit ok_prev = 1'b0;
    int n_cmd [2], t_prev [2], t_rise [2], t_dllrst [2];
    bit cke_p [2], done_p [2];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cmd(input int i);
        case (i)
            0, 5:    return 1;
            6, 7:    return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_ba(input int i);
        case (i)
            1:        return 2;
            2:        return 3;
            3, 9, 10: return 1;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int i);
        case (i)
            0, 5:    return 13'h0400;
            1:       return temp_hi ? 13'h0080 : 13'h0000;
            3, 10:   return emr_cfg & ~13'h0381;
            4:       return 13'h0100;
            8:       return mr_cfg & ~13'h0100;
            9:       return (emr_cfg & ~13'h0001) | 13'h0380;
            default: return 13'h0000;
        endcase
    endfunction

    function automatic string addr_req(input int i);
        case (i)
            1:       return "R5";
            2:       return "R6";
            3:       return "R7";
            4:       return "R8";
            8:       return "R9";
            9, 10:   return "R10";
            0, 5:    return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic int exp_gap(input int d, input int i);
        case (exp_cmd(i))
            1:       return t_rp[d];
            3:       return t_rfc[d];
            default: return t_mrd[d];
        endcase
    endfunction

    task automatic mon(input int d, input logic cke, input logic [1:0] cmd,
                       input logic [1:0] ba, input logic [AW-1:0] addr, input logic done);
        int i;
        int exp_t;
        if (!rst_n) begin
            n_cmd[d] = 0; cke_p[d] = 1'b0; done_p[d] = 1'b0;
            return;
        end
        if (cke && !cke_p[d]) begin
            check(cyc == run_start + t_pwr[d], "R2", "cke rise cycle", cyc, run_start + t_pwr[d]);
            t_rise[d] = cyc;
        end
        if (!cke && cke_p[d]) check(1'b0, "R3", "cke fell", 0, 1);
        if (cmd != 2'd0) begin
            i = n_cmd[d];
            if (!cke) check(1'b0, "R2", "command with cke low", int'(cmd), 0);
            if (i >= 11) begin
                check(1'b0, "R12", "extra command", int'(cmd), 0);
            end else begin
                check(int'(cmd) == exp_cmd(i), "R4", "cmd code", int'(cmd), exp_cmd(i));
                check(int'(ba) == exp_ba(i), "R4", "bank select", int'(ba), exp_ba(i));
                check(addr == exp_addr(i), addr_req(i), "address", int'(addr), int'(exp_addr(i)));
                if (i == 0)
                    check(cyc - t_rise[d] == t_cke[d], "R3", "first PRE delay",
                          cyc - t_rise[d], t_cke[d]);
                else
                    check(cyc - t_prev[d] == exp_gap(d, i - 1), "R11", "gap",
                          cyc - t_prev[d], exp_gap(d, i - 1));
                if (i == 4) t_dllrst[d] = cyc;
                t_prev[d] = cyc;
            end
            n_cmd[d] = n_cmd[d] + 1;
        end
        if (done && !done_p[d]) begin
            exp_t = t_prev[d] + t_mrd[d];
            if (t_dllrst[d] + t_dll[d] > exp_t) exp_t = t_dllrst[d] + t_dll[d];
            check(n_cmd[d] == 11, "R12", "commands before ready", n_cmd[d], 11);
            check(cyc == exp_t, "R12", "ready rise cycle", cyc, exp_t);
        end
        if (!done && done_p[d]) check(1'b0, "R12", "ready fell", 0, 1);
        cke_p[d]  = cke;
        done_p[d] = done;
    endtask

    always @(negedge clk) begin
        #1;
        cyc++;
        if (pwr_ok && rst_n && !ok_prev) run_start = cyc;
        ok_prev = pwr_ok && rst_n;
        mon(0, cke_a, cmd_a, ba_a, addr_a, done_a);
        mon(1, cke_b, cmd_b, ba_b, addr_b, done_b);
    end

    task automatic do_run(input logic [AW-1:0] mr, input logic [AW-1:0] emr,
                          input logic hot, input bit glitch);
        int k;
        @(negedge clk);
        rst_n = 1'b0; pwr_ok = 1'b0;
        mr_cfg = mr; emr_cfg = emr; temp_hi = hot;
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state at the ports
        check({cke_a, cmd_a, ba_a, addr_a, done_a} == '0, "R1", "reset outputs dut",
              int'({cke_a, cmd_a, ba_a, addr_a, done_a}), 0);
        check({cke_b, cmd_b, ba_b, addr_b, done_b} == '0, "R1", "reset outputs dut2",
              int'({cke_b, cmd_b, ba_b, addr_b, done_b}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        if (glitch) begin
            // R2: a broken run of pwr_ok must restart the wait
            repeat (1 + $urandom % 8) @(negedge clk);
            pwr_ok = 1'b1;
            repeat (1 + $urandom % 10) @(negedge clk);
            pwr_ok = 1'b0;
            repeat (1 + $urandom % 3) @(negedge clk);
        end
        pwr_ok = 1'b1;
        k = 0;
        while (!(done_a && done_b) && k < 600) begin
            @(negedge clk);
            k++;
        end
        repeat (10) @(negedge clk);
        #2;
        check(done_a && done_b, "R12", "ready reached", int'({done_a, done_b}), 3);
        check(n_cmd[0] == 11 && n_cmd[1] == 11, "R4", "command count",
              n_cmd[0] * 100 + n_cmd[1], 1111);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_run(13'h1fff, 13'h1fff, 1'b1, 1'b0);
        do_run(13'h0000, 13'h0000, 1'b0, 1'b0);
        for (int r = 0; r < 5; r++)
            do_run(AW'($urandom), AW'($urandom), 1'($urandom), 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule